// File: doc/BRIEF.md
# Transmit Frame Buffer Formatter

This block takes one outgoing packet from a host data stream and lays it out in packet buffer memory in the form the transmit engine expects. The buffer image starts with a zero status field and a byte count, then holds the payload, stretched with zero bytes to the minimum frame size when the packet is short. A closing 16-bit word carries either nothing, for an even length, or the last odd byte together with a control byte whose odd-length flag is set. Every write lands at the next offset of an internal pointer that restarts at zero for each packet and advances by the size of each access.

A packet is started with a one-cycle request carrying its length and the host path width. With the narrow path selected, every access and every stream beat is 16 bits wide. With the wide path selected, the header goes out as one 32-bit longword, the payload as longwords, and any two leftover bytes as a single 16-bit access ahead of the closing word. Stream beats hold bytes in little-endian order, with the first byte in the low bits. The memory port accepts a write in any cycle in which it is not busy. A busy memory stalls both the write and the stream.

Top module: `txf_formatter`

## Requirements
- R1: Out of reset, and whenever no packet is in progress, `fmt_busy`, `fmt_done`, `mem_we` and `in_ready` are all low.
- R2: A start request is taken only while `fmt_busy` is low; a request raised while a packet is in progress has no effect on that packet's writes.
- R3: In narrow mode (`frm_wide`=0) the first write is a 16-bit zero at offset 0 and the second a 16-bit byte count at offset 2, equal to the padded length plus 6.
- R4: A packet length below 60 is raised to 60; the byte count uses the raised length, and payload bytes past the given length are written as zero.
- R5: In wide mode (`frm_wide`=1) the first write is one 32-bit access at offset 0 whose upper 16 bits hold the byte count and whose lower 16 bits are zero.
- R6: Accepted writes go to consecutive offsets starting at 0, each offset being the previous one plus 2 for a 16-bit access (`mem_wide`=0) or 4 for a 32-bit access (`mem_wide`=1). Payload bytes appear in stream order, with the lowest byte lane first.
- R7: For an even padded length, the last write is a 16-bit zero placed directly after the payload.
- R8: For an odd padded length, the last write is a 16-bit word with the final payload byte in bits 7:0 and 0x20 in bits 15:8, so its value is 0x2000 OR that byte.
- R9: In wide mode, when the padded length leaves 2 or 3 bytes after the last full longword, the next two bytes go out as one 16-bit access before the closing word.
- R10: While `mem_busy` is high, `in_ready` is low, and a pending write keeps its offset and data until a cycle with `mem_busy` low.
- R11: While a payload write waits for stream data and `in_valid` is low, no write is issued.
- R12: `fmt_done` is high for exactly one cycle, the cycle after the closing word is accepted, and `fmt_busy` is low on the cycle after that.
- R13: Bytes of the last stream beat that lie at or past the packet length are written as zero, whatever the host drives on them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_start | input | 1 | Start request for a new packet |
| frm_len | input | LEN_W | Payload length in bytes, sampled with the start request |
| frm_wide | input | 1 | Host path width: 0 selects 16-bit, 1 selects 32-bit |
| fmt_busy | output | 1 | A packet is in progress |
| fmt_done | output | 1 | One-cycle pulse after the closing word is written |
| in_valid | input | 1 | Stream beat valid |
| in_data | input | 32 | Stream beat, first byte in bits 7:0; only bits 15:0 are used in 16-bit mode |
| in_ready | output | 1 | Stream beat is taken when in_valid and in_ready are both high |
| mem_we | output | 1 | Write request to packet memory |
| mem_wide | output | 1 | Access size: 0 for 16 bits, 1 for 32 bits |
| mem_addr | output | ADDR_W | Byte offset of the access within the packet buffer |
| mem_wdata | output | 32 | Write data; bits 31:16 are zero for a 16-bit access |
| mem_busy | input | 1 | Memory cannot take a write this cycle |

## Verification
The stall and pacing properties assume that the host, once it raises `in_valid`, keeps it raised and keeps `in_data` unchanged until the beat is taken. They also assume the host supplies exactly as many beats as the length calls for. The bench's stream driver obeys both rules: it holds each beat until it sees `in_ready`, and it inserts gaps only between beats. The memory busy signal is free to toggle in any cycle, and the stall tests toggle it from a pseudo-random sequence while a packet is in flight.

// File: rtl/txf_pkg.sv
package txf_pkg;

    localparam int unsigned HOST_W   = 32;
    localparam logic [7:0]  ODD_FLAG = 8'h20;
    localparam logic [15:0] HDR_BYTES = 16'd6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STAT,
        ST_CNT,
        ST_HDR32,
        ST_PAY,
        ST_HALF,
        ST_CTRL,
        ST_DONE
    } txf_state_e;

    typedef enum logic [2:0] {
        UK_NONE,
        UK_STAT,
        UK_CNT,
        UK_HDR32,
        UK_PAY,
        UK_HALF,
        UK_CTRL
    } txf_unit_e;

    typedef struct packed {
        logic        need;
        logic        wide;
        logic [31:0] data;
    } txf_wr_t;

    function automatic logic [15:0] txf_pad(input logic [15:0] len,
                                            input logic [15:0] min_len);
        return (len < min_len) ? min_len : len;
    endfunction

    function automatic logic [15:0] txf_count(input logic [15:0] plen);
        return plen + HDR_BYTES;
    endfunction

    function automatic logic [31:0] txf_mask(input logic [31:0] d,
                                             input logic [15:0] left);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) begin
            r[8*i +: 8] = (left > 16'(i)) ? d[8*i +: 8] : 8'h00;
        end
        return r;
    endfunction

    function automatic logic [15:0] txf_close(input logic odd,
                                              input logic [7:0] last_b);
        return odd ? {ODD_FLAG, last_b} : 16'h0000;
    endfunction

endpackage

// File: rtl/txf_ptr.sv
module txf_ptr #(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              step,
    input  logic              step_wide,
    output logic [ADDR_W-1:0] ptr
);
    localparam logic [ADDR_W-1:0] STEP_N = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] STEP_W = ADDR_W'(4);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            ptr <= '0;
        end else if (step) begin
            ptr <= ptr + (step_wide ? STEP_W : STEP_N);
        end
    end
endmodule

// File: rtl/txf_lane.sv
module txf_lane
    import txf_pkg::*;
(
    input  txf_unit_e   kind,
    input  logic        wide_q,
    input  logic [15:0] bidx,
    input  logic [15:0] len_q,
    input  logic [15:0] plen_q,
    input  logic        holdv,
    input  logic [7:0]  hold_b,
    input  logic [31:0] in_data,
    output txf_wr_t     wr
);
    logic [15:0] left;
    logic [31:0] masked;
    logic [15:0] cnt;
    logic [7:0]  last_b;
    logic        have_src;

    assign left     = (len_q > bidx) ? (len_q - bidx) : 16'd0;
    assign have_src = (len_q > bidx);
    assign masked   = txf_mask(in_data, left);
    assign cnt      = txf_count(plen_q);
    assign last_b   = holdv ? hold_b : masked[7:0];

    always_comb begin
        wr = '0;
        unique case (kind)
            UK_STAT: begin
                wr.data = 32'h0;
            end
            UK_CNT: begin
                wr.data = {16'h0, cnt};
            end
            UK_HDR32: begin
                wr.wide = 1'b1;
                wr.data = {cnt, 16'h0};
            end
            UK_PAY: begin
                wr.wide = wide_q;
                wr.need = have_src;
                wr.data = wide_q ? masked : {16'h0, masked[15:0]};
            end
            UK_HALF: begin
                wr.need = have_src;
                wr.data = {16'h0, masked[15:0]};
            end
            UK_CTRL: begin
                wr.need = plen_q[0] && !holdv && have_src;
                wr.data = {16'h0, txf_close(plen_q[0], last_b)};
            end
            default: begin
                wr = '0;
            end
        endcase
    end
endmodule

// File: rtl/txf_seq.sv
module txf_seq
    import txf_pkg::*;
#(
    parameter int unsigned LEN_W   = 11,
    parameter int unsigned MIN_LEN = 60
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frm_start,
    input  logic [LEN_W-1:0] frm_len,
    input  logic             frm_wide,
    input  logic             accept,
    input  logic             beat_taken,
    input  logic [31:0]      in_data,
    output txf_unit_e        kind,
    output logic             take_start,
    output logic             wide_q,
    output logic [15:0]      bidx,
    output logic [15:0]      len_q,
    output logic [15:0]      plen_q,
    output logic             holdv,
    output logic [7:0]       hold_b,
    output logic             busy,
    output logic             done
);
    localparam logic [15:0] MIN16 = 16'(MIN_LEN);

    txf_state_e st, st_n;
    logic [15:0] unit_sz;
    logic [15:0] rem_after;

    assign unit_sz    = wide_q ? 16'd4 : 16'd2;
    assign rem_after  = plen_q - bidx - unit_sz;
    assign take_start = (st == ST_IDLE) && frm_start;
    assign busy       = (st != ST_IDLE);
    assign done       = (st == ST_DONE);

    always_comb begin
        unique case (st)
            ST_STAT:  kind = UK_STAT;
            ST_CNT:   kind = UK_CNT;
            ST_HDR32: kind = UK_HDR32;
            ST_PAY:   kind = UK_PAY;
            ST_HALF:  kind = UK_HALF;
            ST_CTRL:  kind = UK_CTRL;
            default:  kind = UK_NONE;
        endcase
    end

    always_comb begin
        st_n = st;
        unique case (st)
            ST_IDLE: begin
                if (frm_start) st_n = frm_wide ? ST_HDR32 : ST_STAT;
            end
            ST_STAT: begin
                if (accept) st_n = ST_CNT;
            end
            ST_CNT, ST_HDR32: begin
                if (accept) st_n = ST_PAY;
            end
            ST_PAY: begin
                if (accept) begin
                    if (rem_after >= unit_sz)           st_n = ST_PAY;
                    else if (wide_q && rem_after >= 2)  st_n = ST_HALF;
                    else                                st_n = ST_CTRL;
                end
            end
            ST_HALF: begin
                if (accept) st_n = ST_CTRL;
            end
            ST_CTRL: begin
                if (accept) st_n = ST_DONE;
            end
            default: begin
                st_n = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            wide_q <= 1'b0;
            bidx   <= '0;
            len_q  <= '0;
            plen_q <= '0;
            holdv  <= 1'b0;
            hold_b <= '0;
        end else begin
            st <= st_n;
            if (take_start) begin
                wide_q <= frm_wide;
                bidx   <= '0;
                len_q  <= 16'(frm_len);
                plen_q <= txf_pad(16'(frm_len), MIN16);
                holdv  <= 1'b0;
            end else if (accept) begin
                if (st == ST_PAY) begin
                    bidx <= bidx + unit_sz;
                end else if (st == ST_HALF) begin
                    bidx <= bidx + 16'd2;
                    if (beat_taken) begin
                        holdv  <= 1'b1;
                        hold_b <= in_data[23:16];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/txf_formatter.sv
module txf_formatter
    import txf_pkg::*;
#(
    parameter int unsigned LEN_W   = 11,
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned MIN_LEN = 60
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_start,
    input  logic [LEN_W-1:0]  frm_len,
    input  logic              frm_wide,
    output logic              fmt_busy,
    output logic              fmt_done,
    input  logic              in_valid,
    input  logic [31:0]       in_data,
    output logic              in_ready,
    output logic              mem_we,
    output logic              mem_wide,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_busy
);
    txf_unit_e   kind;
    txf_wr_t     wr;
    logic        take_start;
    logic        wide_q;
    logic [15:0] bidx;
    logic [15:0] len_q;
    logic [15:0] plen_q;
    logic        holdv;
    logic [7:0]  hold_b;
    logic        accept;
    logic        beat_taken;
    logic        unit_live;

    assign unit_live  = (kind != UK_NONE);
    assign in_ready   = unit_live && wr.need && !mem_busy;
    assign mem_we     = unit_live && (!wr.need || in_valid);
    assign accept     = mem_we && !mem_busy;
    assign beat_taken = in_valid && in_ready;
    assign mem_wide   = wr.wide;
    assign mem_wdata  = wr.data;

    txf_seq #(
        .LEN_W  (LEN_W),
        .MIN_LEN(MIN_LEN)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .frm_start (frm_start),
        .frm_len   (frm_len),
        .frm_wide  (frm_wide),
        .accept    (accept),
        .beat_taken(beat_taken),
        .in_data   (in_data),
        .kind      (kind),
        .take_start(take_start),
        .wide_q    (wide_q),
        .bidx      (bidx),
        .len_q     (len_q),
        .plen_q    (plen_q),
        .holdv     (holdv),
        .hold_b    (hold_b),
        .busy      (fmt_busy),
        .done      (fmt_done)
    );

    txf_lane u_lane (
        .kind   (kind),
        .wide_q (wide_q),
        .bidx   (bidx),
        .len_q  (len_q),
        .plen_q (plen_q),
        .holdv  (holdv),
        .hold_b (hold_b),
        .in_data(in_data),
        .wr     (wr)
    );

    txf_ptr #(
        .ADDR_W(ADDR_W)
    ) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .clear    (take_start),
        .step     (accept),
        .step_wide(wr.wide),
        .ptr      (mem_addr)
    );
endmodule

// File: rtl/txf_formatter_chk.sv
module txf_formatter_chk #(
    parameter int unsigned ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              frm_start,
    input logic              fmt_busy,
    input logic              fmt_done,
    input logic              in_valid,
    input logic              in_ready,
    input logic              mem_we,
    input logic              mem_wide,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              mem_busy
);
    logic [ADDR_W-1:0] next_off;

    always_ff @(posedge clk) begin
        if (rst) begin
            next_off <= '0;
        end else if (!fmt_busy && frm_start) begin
            next_off <= '0;
        end else if (mem_we && !mem_busy) begin
            next_off <= mem_addr + (mem_wide ? ADDR_W'(4) : ADDR_W'(2));
        end
    end

    // R1: quiet when idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !fmt_busy |-> (!mem_we && !in_ready && !fmt_done));

    // R3 / R5: the header's low half is always the zero status field
    p_hdr_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_we && mem_addr == '0) |-> (mem_wdata[15:0] == 16'h0));

    // R6: offsets follow each other by access size
    p_addr_seq_r6: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr == next_off));

    // R10: busy memory blocks the stream
    p_busy_noready_r10: assert property (@(posedge clk) disable iff (rst)
        mem_busy |-> !in_ready);

    // R10: stalled write held steady
    p_stall_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_we && mem_busy) |=> (mem_we && $stable(mem_addr) && $stable(mem_wdata)));

    // R11: no data, no write
    p_noval_nowrite_r11: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |-> !mem_we);

    // R12: done is a single-cycle pulse followed by idle
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        fmt_done |=> (!fmt_done && !fmt_busy));
endmodule

bind txf_formatter txf_formatter_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .frm_start(frm_start),
    .fmt_busy (fmt_busy),
    .fmt_done (fmt_done),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .mem_we   (mem_we),
    .mem_wide (mem_wide),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_busy (mem_busy)
);

// File: tb/txf_formatter_tb.sv
module txf_formatter_tb_top;
    localparam int PERIOD = 10;
    localparam int LEN_W  = 11;
    localparam int ADDR_W = 12;
    localparam int LOGN   = 1200;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              frm_start = 1'b0;
    logic [LEN_W-1:0]  frm_len = '0;
    logic              frm_wide = 1'b0;
    logic              fmt_busy, fmt_done;
    logic              in_valid = 1'b0;
    logic [31:0]       in_data = '0;
    logic              in_ready;
    logic              mem_we, mem_wide;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0]       mem_wdata;
    logic              mem_busy = 1'b0;

    int checks = 0;
    int errors = 0;

    logic [7:0]  pay [0:2047];
    logic [31:0] got_addr [0:LOGN-1];
    logic        got_wide [0:LOGN-1];
    logic [31:0] got_data [0:LOGN-1];
    int          got_n = 0;
    logic [31:0] exp_addr [0:LOGN-1];
    logic        exp_wide [0:LOGN-1];
    logic [31:0] exp_data [0:LOGN-1];
    int          exp_n = 0;
    int          done_cnt = 0;
    int          stall_seen = 0;
    int          stall_bad = 0;
    logic        busy_en = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    txf_formatter #(.LEN_W(LEN_W), .ADDR_W(ADDR_W), .MIN_LEN(60)) dut_i (
        .clk(clk), .rst(rst), .frm_start(frm_start), .frm_len(frm_len),
        .frm_wide(frm_wide), .fmt_busy(fmt_busy), .fmt_done(fmt_done),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .mem_we(mem_we), .mem_wide(mem_wide), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_busy(mem_busy)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // memory busy pattern
    initial begin
        forever begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            mem_busy = busy_en && (lfsr[1:0] == 2'b00);
        end
    end

    // write monitor, sampled mid low phase
    initial begin
        logic        p_stall = 1'b0;
        logic [31:0] p_addr = '0;
        logic [31:0] p_data = '0;
        forever begin
            @(negedge clk);
            #2;
            if (p_stall) begin
                if (!(mem_we && 32'(mem_addr) == p_addr && mem_wdata == p_data))
                    stall_bad++;
            end
            p_stall = mem_we && mem_busy;
            p_addr  = 32'(mem_addr);
            p_data  = mem_wdata;
            if (mem_we && mem_busy) stall_seen++;
            if (mem_we && !mem_busy && got_n < LOGN) begin
                got_addr[got_n] = 32'(mem_addr);
                got_wide[got_n] = mem_wide;
                got_data[got_n] = mem_wdata;
                got_n++;
            end
            if (fmt_done) done_cnt++;
        end
    end

    initial begin
        #(PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    function automatic logic [7:0] eb(input int i, input int len);
        return (i < len) ? pay[i] : 8'h00;
    endfunction

    task automatic push_exp(input int a, input bit w, input logic [31:0] d);
        exp_addr[exp_n] = 32'(a);
        exp_wide[exp_n] = w;
        exp_data[exp_n] = d;
        exp_n++;
    endtask

    task automatic build_exp(input int len, input bit wide);
        int pl = (len < 60) ? 60 : len;
        int a;
        exp_n = 0;
        if (!wide) begin
            push_exp(0, 1'b0, 32'h0);
            push_exp(2, 1'b0, 32'(pl + 6));
            a = 4;
            for (int k = 0; k < pl / 2; k++) begin
                push_exp(a, 1'b0, {16'h0, eb(2*k+1, len), eb(2*k, len)});
                a += 2;
            end
        end else begin
            push_exp(0, 1'b1, {16'(pl + 6), 16'h0});
            a = 4;
            for (int k = 0; k < pl / 4; k++) begin
                push_exp(a, 1'b1, {eb(4*k+3, len), eb(4*k+2, len),
                                   eb(4*k+1, len), eb(4*k, len)});
                a += 4;
            end
            if ((pl % 4) >= 2) begin
                push_exp(a, 1'b0, {16'h0, eb(a-3, len), eb(a-4, len)});
                a += 2;
            end
        end
        if (pl % 2 == 1) push_exp(a, 1'b0, {16'h0, 8'h20, eb(pl-1, len)});
        else             push_exp(a, 1'b0, 32'h0);
    endtask

    task automatic drive_beats(input int len, input bit wide, input int gap);
        int bw = wide ? 4 : 2;
        int nb = (len + bw - 1) / bw;
        for (int j = 0; j < nb; j++) begin
            if (gap > 0 && (j % 3) == 1) begin
                in_valid = 1'b0;
                repeat (gap) @(negedge clk);
            end
            in_valid = 1'b1;
            for (int i = 0; i < 4; i++) begin
                int bi = j * bw + i;
                in_data[8*i +: 8] = (i < bw && bi < len) ? pay[bi] : 8'hA5;
            end
            forever begin
                #3;
                if (in_ready) begin
                    @(negedge clk);
                    break;
                end
                @(negedge clk);
            end
        end
        in_valid = 1'b0;
    endtask

    task automatic run_frame(input int len, input bit wide, input int gap,
                             input bit stall, input bit intrude, input string req);
        int d0;
        int mism = 0;
        int first_bad = -1;
        for (int i = 0; i < 2048; i++) pay[i] = 8'((i * 37 + len * 11 + 5) & 8'hFF);
        build_exp(len, wide);
        @(negedge clk);
        got_n = 0;
        d0 = done_cnt;
        busy_en = stall;
        frm_start = 1'b1;
        frm_len = LEN_W'(len);
        frm_wide = wide;
        @(negedge clk);
        frm_start = 1'b0;
        fork
            drive_beats(len, wide, gap);
            begin
                if (intrude) begin
                    repeat (4) @(negedge clk);
                    frm_start = 1'b1;
                    frm_len = LEN_W'(3);
                    frm_wide = !wide;
                    @(negedge clk);
                    frm_start = 1'b0;
                end
            end
        join
        for (int t = 0; t < 4000 && done_cnt == d0; t++) @(negedge clk);
        busy_en = 1'b0;
        @(negedge clk);
        #2;
        check(got_n == exp_n, req, "write count", 32'(got_n), 32'(exp_n));
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            if (got_addr[i] != exp_addr[i] || got_wide[i] != exp_wide[i] ||
                got_data[i] != exp_data[i]) begin
                mism++;
                if (first_bad < 0) first_bad = i;
            end
        end
        if (first_bad >= 0)
            check(1'b0, req, $sformatf("write %0d addr=%h/%h wide=%0d/%0d data",
                  first_bad, got_addr[first_bad], exp_addr[first_bad],
                  got_wide[first_bad], exp_wide[first_bad]),
                  got_data[first_bad], exp_data[first_bad]);
        else
            check(1'b1, req, "writes", 32'(mism), 32'h0);
        check(done_cnt == d0 + 1, "R12", "done pulses", 32'(done_cnt - d0), 32'h1);
        check(!fmt_busy, "R12", "idle after done", 32'(fmt_busy), 32'h0);
    endtask

    task automatic t_reset;
        #2;
        check(!fmt_busy && !fmt_done && !mem_we && !in_ready, "R1", "reset outputs",
              {28'h0, fmt_busy, fmt_done, mem_we, in_ready}, 32'h0);
    endtask

    task automatic t_short_narrow;  run_frame(20, 1'b0, 0, 1'b0, 1'b0, "R4");  endtask
    task automatic t_even_narrow;   run_frame(100, 1'b0, 0, 1'b0, 1'b0, "R7"); endtask
    task automatic t_odd_narrow;    run_frame(101, 1'b0, 0, 1'b0, 1'b0, "R8"); endtask
    task automatic t_wide_even4;    run_frame(64, 1'b1, 0, 1'b0, 1'b0, "R5");  endtask
    task automatic t_wide_rem2;     run_frame(66, 1'b1, 0, 1'b0, 1'b0, "R9");  endtask
    task automatic t_wide_rem3;     run_frame(67, 1'b1, 0, 1'b0, 1'b0, "R9");  endtask
    task automatic t_wide_rem1;     run_frame(65, 1'b1, 0, 1'b0, 1'b0, "R6");  endtask
    task automatic t_mask_tail;     run_frame(3, 1'b1, 0, 1'b0, 1'b0, "R13");  endtask
    task automatic t_mask_narrow;   run_frame(61, 1'b0, 0, 1'b0, 1'b0, "R3");  endtask
    task automatic t_gaps;          run_frame(77, 1'b0, 2, 1'b0, 1'b0, "R11"); endtask
    task automatic t_intrude;       run_frame(70, 1'b1, 0, 1'b0, 1'b1, "R2");  endtask

    task automatic t_stall;
        int s0 = stall_seen;
        stall_bad = 0;
        run_frame(83, 1'b1, 1, 1'b1, 1'b0, "R10");
        check(stall_seen > s0, "R10", "stall cycles seen", 32'(stall_seen - s0), 32'h1);
        check(stall_bad == 0, "R10", "stalled write changed", 32'(stall_bad), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_short_narrow();
        t_even_narrow();
        t_odd_narrow();
        t_mask_narrow();
        t_wide_even4();
        t_wide_rem2();
        t_wide_rem3();
        t_wide_rem1();
        t_mask_tail();
        t_gaps();
        t_intrude();
        t_stall();
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule